// File: doc/BRIEF.md
# Speculative Stack-Pointer Delta Engine

This block sits at the tail of the decode stage. It takes in a stream of uops and folds every implicit stack-pointer change (push, pop, immediate stack adjustment) into a small signed delta register held in the front end. A private adder updates the delta. The engine therefore never sends an ALU uop downstream for those updates. Push and pop still travel downstream as memory uops, each tagged with the byte offset from the architectural stack pointer that its access uses. Pure adjustments are absorbed and disappear from the stream.

When a uop names the stack pointer explicitly, the architectural register must be current first. The engine emits a synchronization uop ("SP += offset") that carries the accumulated delta, clears the delta, and then lets the waiting uop through. The same synchronization is forced when an update would carry the delta outside its signed range. A flush clears the delta and abandons any synchronization in flight.

Both sides are valid/ready streams. An input uop is consumed on a cycle where `in_valid` and `in_ready` are both high. An output uop is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output fields hold still and no input is consumed. The upstream side must likewise hold its uop stable until it is consumed. `out_ready` feeds combinationally into `in_ready`. Kind encoding on `in_kind`/`out_kind`: 0 ordinary, 1 push, 2 pop, 3 stack adjust, 4 explicit stack-pointer use, 5 sync (output only). Input codes 5 to 7 are treated as ordinary.

Top module: `sp_delta_engine`

## Requirements
- R1: An ordinary uop (kind 0) leaves with the same kind and payload, with offset 0, and leaves the delta unchanged.
- R2: A push (kind 1) lowers the delta by 4 bytes, or by 8 when `in_wide` is 1. It leaves as kind 1 with offset equal to the lowered delta.
- R3: A pop (kind 2) raises the delta by 4 bytes, or by 8 when `in_wide` is 1. It leaves as kind 1's counterpart kind 2, with offset equal to the delta before the pop.
- R4: A stack adjust (kind 3) adds the sign-extended 8-bit `in_imm` to the delta and produces no output uop.
- R5: An explicit stack-pointer use (kind 4) that arrives while the delta is nonzero is held back. A sync uop (kind 5, payload 0, offset equal to the delta) is presented first. Its acceptance clears the delta, and the kind-4 uop then leaves with offset 0.
- R6: An explicit stack-pointer use while the delta is zero passes at once with no sync uop.
- R7: A push, pop or adjust whose result would fall outside -128..127 first causes a sync uop that carries the current delta. The update is then applied starting from zero.
- R8: While `flush` is high, `out_valid` and `in_ready` are low, and the delta is zero on the next cycle. A pending sync is dropped.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output kind, offset and payload stay stable.
- R10: After synchronous reset the delta is zero, so the first explicit stack-pointer use passes with no sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Pipeline flush; clears the delta |
| in_valid | input | 1 | Input uop valid |
| in_ready | output | 1 | Input uop accepted this cycle when valid |
| in_kind | input | 3 | Input uop kind code |
| in_wide | input | 1 | 1 selects 8-byte stack slots, 0 selects 4-byte |
| in_imm | input | 8 | Signed adjustment for kind 3 |
| in_payload | input | 32 | Opaque uop body passed through |
| out_valid | output | 1 | Output uop valid |
| out_ready | input | 1 | Downstream accepts output uop |
| out_kind | output | 3 | Output uop kind code |
| out_offset | output | 8 | Signed stack offset or sync amount |
| out_payload | output | 32 | Passed uop body, 0 for sync |

## Verification
Three things can fall in one cycle: a sync that is waiting on back-pressure, the next stack update that must wait behind it, and a flush that arrives while the sync is stalled. The bench provokes this by building up a delta, presenting an explicit stack-pointer use with `out_ready` held low, and then raising `flush`. A random run with about 2% flushes and 70% downstream readiness repeats the pattern. A cycle-level bench model of the delta judges each cycle. It checks that the sync vanishes, that the delta restarts at zero (the next explicit use passes without a sync), and that no input was consumed while the output was stalled.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_PLAIN = 3'd0,
    K_PUSH  = 3'd1,
    K_POP   = 3'd2,
    K_ADJ   = 3'd3,
    K_SPUSE = 3'd4,
    K_SYNC  = 3'd5
  } uop_kind_e;

  typedef struct packed {
    logic is_push;
    logic is_pop;
    logic is_adj;
    logic uses_sp;
  } uop_class_t;
endpackage

// File: rtl/sp_uop_classify.sv
`timescale 1ns/1ps
module sp_uop_classify
  import sp_pkg::*;
#(
  parameter int DELTA_W      = 8,
  parameter int IMM_W        = 8,
  parameter int NARROW_BYTES = 4,
  parameter int WIDE_BYTES   = 8
) (
  input  logic [KIND_W-1:0]  kind,
  input  logic               wide,
  input  logic [IMM_W-1:0]   imm,
  output uop_class_t         cls,
  output logic [DELTA_W-1:0] amount
);
  logic [DELTA_W-1:0] slot_bytes;
  logic [DELTA_W-1:0] imm_ext;

  assign slot_bytes = wide ? DELTA_W'(WIDE_BYTES) : DELTA_W'(NARROW_BYTES);
  assign imm_ext    = DELTA_W'($signed(imm));

  always_comb begin
    cls    = '0;
    amount = '0;
    case (kind)
      K_PUSH: begin
        cls.is_push = 1'b1;
        amount      = -slot_bytes;
      end
      K_POP: begin
        cls.is_pop = 1'b1;
        amount     = slot_bytes;
      end
      K_ADJ: begin
        cls.is_adj = 1'b1;
        amount     = imm_ext;
      end
      K_SPUSE: cls.uses_sp = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_delta_adder.sv
`timescale 1ns/1ps
module sp_delta_adder #(
  parameter int DELTA_W = 8
) (
  input  logic [DELTA_W-1:0] delta,
  input  logic [DELTA_W-1:0] amount,
  output logic [DELTA_W-1:0] sum,
  output logic               ovf
);
  logic [DELTA_W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DELTA_W; i++) begin : g_bit
    assign sum[i]     = delta[i] ^ amount[i] ^ carry[i];
    assign carry[i+1] = (delta[i] & amount[i]) | (carry[i] & (delta[i] ^ amount[i]));
  end

  assign ovf = carry[DELTA_W] ^ carry[DELTA_W-1];
endmodule

// File: rtl/sp_stream_ctl.sv
`timescale 1ns/1ps
module sp_stream_ctl
  import sp_pkg::*;
(
  input  logic       in_valid,
  input  logic       out_ready,
  input  logic       flush,
  input  uop_class_t cls,
  input  logic       delta_nz,
  input  logic       sum_ovf,
  output logic       need_sync,
  output logic       out_valid,
  output logic       in_ready,
  output logic       load_sum,
  output logic       clear_delta
);
  logic modifies;

  assign modifies    = cls.is_push | cls.is_pop | cls.is_adj;
  assign need_sync   = in_valid & ~flush &
                       ((cls.uses_sp & delta_nz) | (modifies & sum_ovf));
  assign out_valid   = in_valid & ~flush & (need_sync | ~cls.is_adj);
  assign in_ready    = ~flush & ~need_sync & (cls.is_adj | out_ready);
  assign load_sum    = in_valid & in_ready & modifies;
  assign clear_delta = flush | (need_sync & out_ready);
endmodule

// File: rtl/sp_delta_engine.sv
`timescale 1ns/1ps
module sp_delta_engine
  import sp_pkg::*;
#(
  parameter int DELTA_W      = 8,
  parameter int IMM_W        = 8,
  parameter int PAYLOAD_W    = 32,
  parameter int NARROW_BYTES = 4,
  parameter int WIDE_BYTES   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [KIND_W-1:0]    in_kind,
  input  logic                 in_wide,
  input  logic [IMM_W-1:0]     in_imm,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [KIND_W-1:0]    out_kind,
  output logic [DELTA_W-1:0]   out_offset,
  output logic [PAYLOAD_W-1:0] out_payload
);
  uop_class_t         cls;
  logic [DELTA_W-1:0] amount;
  logic [DELTA_W-1:0] delta_q;
  logic [DELTA_W-1:0] sum;
  logic               sum_ovf;
  logic               need_sync;
  logic               load_sum;
  logic               clear_delta;

  sp_uop_classify #(
    .DELTA_W(DELTA_W), .IMM_W(IMM_W),
    .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
  ) u_cls (
    .kind(in_kind), .wide(in_wide), .imm(in_imm),
    .cls(cls), .amount(amount)
  );

  sp_delta_adder #(.DELTA_W(DELTA_W)) u_add (
    .delta(delta_q), .amount(amount), .sum(sum), .ovf(sum_ovf)
  );

  sp_stream_ctl u_ctl (
    .in_valid(in_valid), .out_ready(out_ready), .flush(flush),
    .cls(cls), .delta_nz(|delta_q), .sum_ovf(sum_ovf),
    .need_sync(need_sync), .out_valid(out_valid), .in_ready(in_ready),
    .load_sum(load_sum), .clear_delta(clear_delta)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_delta) delta_q <= '0;
    else if (load_sum)      delta_q <= sum;
  end

  always_comb begin
    if (need_sync) begin
      out_kind    = K_SYNC;
      out_offset  = delta_q;
      out_payload = '0;
    end else begin
      out_kind    = (in_kind > K_SPUSE) ? K_PLAIN : in_kind;
      out_payload = in_payload;
      if (cls.is_push)     out_offset = sum;
      else if (cls.is_pop) out_offset = delta_q;
      else                 out_offset = '0;
    end
  end
endmodule

// File: rtl/sp_delta_engine_chk.sv
`timescale 1ns/1ps
module sp_delta_engine_chk
  import sp_pkg::*;
#(
  parameter int DELTA_W   = 8,
  parameter int PAYLOAD_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 flush,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [KIND_W-1:0]    in_kind,
  input logic [PAYLOAD_W-1:0] in_payload,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [KIND_W-1:0]    out_kind,
  input logic [DELTA_W-1:0]   out_offset,
  input logic [PAYLOAD_W-1:0] out_payload,
  input logic [DELTA_W-1:0]   delta_q
);
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!out_valid && !in_ready)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (delta_q == '0)); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (flush || (out_valid && $stable(out_kind) && $stable(out_offset) && $stable(out_payload)))); // R9
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_kind == K_SYNC) |=> (delta_q == '0)); // R5
  AST_SYNC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == K_SYNC) |-> !in_ready); // R5
  AST_NO_EMPTY_SYNC: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == K_SYNC) |-> (out_offset != '0)); // R6
  AST_ADJ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == K_ADJ && out_valid) |-> (out_kind == K_SYNC)); // R4
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind != K_SYNC) |-> (out_payload == in_payload)); // R1
  AST_DELTA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!flush && !(in_valid && in_ready) && !(out_valid && out_ready && out_kind == K_SYNC)) |=> $stable(delta_q)); // R9
endmodule

bind sp_delta_engine sp_delta_engine_chk #(.DELTA_W(DELTA_W), .PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_payload(in_payload), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_offset(out_offset),
  .out_payload(out_payload), .delta_q(delta_q)
);

// File: tb/tb_sp_delta_engine.sv
`timescale 1ns/1ps
module tb_sp_delta_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = 3'd0;
  logic        in_wide = 1'b0;
  logic [7:0]  in_imm = 8'd0;
  logic [31:0] in_payload = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_kind;
  logic [7:0]  out_offset;
  logic [31:0] out_payload;

  int    n_chk = 0;
  int    n_fail = 0;
  int    m_delta = 0;
  string force_tag = "";

  always #2.5 clk = ~clk;

  sp_delta_engine dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_wide(in_wide), .in_imm(in_imm), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_offset(out_offset), .out_payload(out_payload)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int step_amount(input logic [2:0] k, input logic w, input logic [7:0] imm);
    if (k == 3'd1) return -(w ? 8 : 4);
    if (k == 3'd2) return (w ? 8 : 4);
    if (k == 3'd3) return int'($signed(imm));
    return 0;
  endfunction

  task automatic cyc(input logic v, input logic [2:0] k, input logic w, input logic [7:0] imm,
                     input logic [31:0] pay, input logic ordy, input logic fl, output logic fired);
    int sum, nd, ek, eoff;
    logic ev, er, ovf, modf;
    logic [31:0] epay;
    string tg;
    @(negedge clk);
    in_valid = v; in_kind = k; in_wide = w; in_imm = imm; in_payload = pay;
    out_ready = ordy; flush = fl;
    #1;
    modf = (k == 3'd1) || (k == 3'd2) || (k == 3'd3);
    sum  = m_delta + step_amount(k, w, imm);
    ovf  = modf && (sum > 127 || sum < -128);
    nd = m_delta; ev = 1'b0; er = 1'b0; ek = 0; eoff = 0; epay = '0; tg = "R1";
    if (fl) begin
      nd = 0; tg = "R8";
    end else if (v) begin
      if ((k == 3'd4 && m_delta != 0) || ovf) begin
        ev = 1'b1; ek = 5; eoff = m_delta; tg = ovf ? "R7" : "R5";
        if (ordy) nd = 0;
      end else if (k == 3'd3) begin
        er = 1'b1; nd = sum; tg = "R4";
      end else begin
        ev = 1'b1; er = ordy; ek = int'(k); epay = pay;
        eoff = (k == 3'd1) ? sum : (k == 3'd2) ? m_delta : 0;
        tg = (k == 3'd1) ? "R2" : (k == 3'd2) ? "R3" : (k == 3'd4) ? "R6" : "R1";
        if (ordy && (k == 3'd1 || k == 3'd2)) nd = sum;
      end
    end
    if (ev && !ordy) tg = "R9";
    if (force_tag != "") tg = force_tag;
    chk(tg, "out_valid", int'(out_valid), int'(ev));
    if (v || fl) chk(tg, "in_ready", int'(in_ready), int'(er));
    if (ev) begin
      chk(tg, "out_kind", int'(out_kind), ek);
      chk(tg, "out_offset", int'($signed(out_offset)), eoff);
      chk(tg, "out_payload", int'(out_payload), int'(epay));
    end
    fired = v && !fl && er;
    m_delta = nd;
  endtask

  task automatic send(input logic [2:0] k, input logic w, input logic [7:0] imm,
                      input logic [31:0] pay, input int pct);
    logic f = 1'b0;
    for (int i = 0; i < 400 && !f; i++)
      cyc(1'b1, k, w, imm, pay, ($urandom_range(99) < pct), 1'b0, f);
  endtask

  task automatic idle(input int n);
    logic f;
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 1'b0, 8'd0, 32'd0, 1'b1, 1'b0, f);
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic f;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: idle after reset, then an explicit use with no sync
    @(negedge clk); #1;
    chk("R10", "out_valid after reset", int'(out_valid), 0);
    force_tag = "R10";
    send(3'd4, 1'b0, 8'd0, 32'hA000_0001, 100);
    force_tag = "";
    // R2, R3, R4 directed
    send(3'd1, 1'b0, 8'd0, 32'h11, 100);
    send(3'd1, 1'b1, 8'd0, 32'h12, 100);
    send(3'd2, 1'b0, 8'd0, 32'h13, 100);
    send(3'd3, 1'b0, 8'd20, 32'h14, 100);
    send(3'd3, 1'b0, 8'hFD, 32'h15, 100);
    // R5 then R6
    send(3'd4, 1'b0, 8'd0, 32'h16, 100);
    send(3'd4, 1'b1, 8'd0, 32'h17, 100);
    send(3'd0, 1'b0, 8'd0, 32'hDEAD_BEEF, 100);
    // R7: 16 wide pushes reach -128, the 17th forces a sync
    for (int i = 0; i < 17; i++) send(3'd1, 1'b1, 8'd0, 32'h100 + i, 100);
    send(3'd3, 1'b0, 8'd100, 32'h200, 100);
    send(3'd3, 1'b0, 8'd100, 32'h201, 100);
    send(3'd3, 1'b0, 8'd100, 32'h202, 100);
    // R9: stall a pending sync, then release
    send(3'd1, 1'b0, 8'd0, 32'h300, 100);
    for (int i = 0; i < 4; i++) cyc(1'b1, 3'd4, 1'b0, 8'd0, 32'h301, 1'b0, 1'b0, f);
    send(3'd4, 1'b0, 8'd0, 32'h301, 100);
    // R8: flush while a sync waits under back-pressure
    send(3'd2, 1'b1, 8'd0, 32'h400, 100);
    cyc(1'b1, 3'd4, 1'b0, 8'd0, 32'h401, 1'b0, 1'b0, f);
    cyc(1'b1, 3'd4, 1'b0, 8'd0, 32'h401, 1'b0, 1'b1, f);
    force_tag = "R8";
    send(3'd4, 1'b0, 8'd0, 32'h402, 100);
    force_tag = "";
    idle(2);
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(99);
      logic [2:0] k = (r < 30) ? 3'd1 : (r < 55) ? 3'd2 : (r < 70) ? 3'd3 : (r < 82) ? 3'd4 : 3'd0;
      logic w = 1'($urandom_range(1));
      logic [7:0] imm = 8'($signed($urandom_range(80)) - 40);
      logic [31:0] pay = $urandom;
      if ($urandom_range(99) < 2) begin
        cyc(1'b1, k, w, imm, pay, 1'b0, 1'b0, f);
        cyc(1'b1, k, w, imm, pay, 1'b0, 1'b1, f);
      end else begin
        send(k, w, imm, pay, 70);
      end
      if ($urandom_range(99) < 10) idle(1);
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule